// File: doc/BRIEF.md
# Sensorless Spindle Start-up Sequencer

This block is the digital controller that brings a three-phase spindle motor up to speed without position sensors. While the enable input requests drive, it first steps the motor through the six commutation states open-loop. Each state is held for a whole number of base-oscillator ticks, and the hold time grows while no back-EMF has been seen. After a set number of zero-cross pulses from the external back-EMF comparator, the sequencer hands commutation over to those pulses: every crossing advances one state.

A stop detector watches the running motor. If too many ticks pass without a crossing, the start is tried again straight away from the first short step. When the restart-inhibit input is high, the block parks with every phase floating instead. The three-level enable pin arrives as a pair of samples, one taken with a pull-up and one with a pull-down. From these the block decodes drive, cut-off (all phases floating) or brake (all phases sinking). Brake is stretched by a minimum hold when the pin is released to open.

Top module: `spin_start_seq`

## Requirements
- R1: `en_sense` = {pull-up sample, pull-down sample} decodes as 2'b11 drive, 2'b00 brake and 2'b10 open. 2'b01 is also treated as open. In brake every phase code is sink at once. In open, tick and zc have no effect and all phases are off.
- R2: While `rst_n` is low, `phase_cmd` is 0, and `sync_mode` and `halted` are 0.
- R3: Phase codes are off=2'b00, source=2'b01 and sink=2'b10, with U in bits [1:0], V in [3:2] and W in [5:4]. Code 2'b11 never appears. The steps 0..5 drive source/sink as U/V, U/W, V/W, V/U, W/U and W/V, and step 5 wraps to step 0.
- R4: At the first clock edge with drive requested, the block enters forced commutation at step 0. Each of the first FIRST_N (5) steps lasts START_LEN (4) `tick` pulses. Cycles without `tick` do not count.
- R5: Each forced step after those lasts LEN_INC (2) ticks longer than the step before it, up to a ceiling of MAX_LEN (16) ticks.
- R6: During forced commutation, the LOCK_ZC-th (2nd) `zc` pulse sets `sync_mode` at the next edge without changing the step. Earlier pulses leave the step unchanged.
- R7: While `sync_mode` is 1, each `zc` pulse advances one step at the next edge, and `tick` alone never advances the step.
- R8: While `sync_mode` is 1 with `restart_inh` low, the STALL_TICKS-th tick since the last crossing restarts forced commutation at step 0 on that edge. The restarted first step again lasts START_LEN ticks.
- R9: If that stall occurs with `restart_inh` high, `halted` becomes 1 and all phases go off. `tick`, `zc` and `restart_inh` are then ignored until the enable leaves drive.
- R10: Open or brake returns the sequencer to idle at the next edge. A later drive request starts again from step 0 with START_LEN-tick steps.
- R11: When `en_sense` goes from brake to open, every phase stays sink until the BRAKE_CYC-th rising edge after the change, then turns off. Going from brake to drive leaves no pending hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| en_sense | input | 2 | Enable pin samples {with pull-up, with pull-down} |
| tick | input | 1 | One-cycle pulse per base oscillator period T |
| zc | input | 1 | One-cycle pulse per back-EMF zero crossing |
| restart_inh | input | 1 | High blocks automatic restart after a stall |
| phase_cmd | output | 6 | Per-phase source/sink/off codes, W:V:U |
| sync_mode | output | 1 | High while commutation follows back-EMF |
| halted | output | 1 | High while parked after an inhibited restart |

## Verification
The properties assume that `en_sense`, `tick` and `zc` are already synchronous to `clk`. They also assume that `tick` and `zc` are single-cycle pulses, and that the brake hold runs only out of a genuine brake request. The stimulus changes every input half a cycle away from the sampling edge. Across the forced phase it keeps `tick` and `zc` in separate cycles, so each step length and each crossing count has one expected outcome. A back-EMF crossing is never placed on the tick that completes a stall window.

// File: rtl/sss_pkg.sv
package sss_pkg;
   typedef enum logic [1:0] {
      PH_OFF = 2'b00,
      PH_SRC = 2'b01,
      PH_SNK = 2'b10
   } ph_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FORCE,
      ST_SYNC,
      ST_HALT
   } seq_st_e;

   localparam int NUM_PH   = 3;
   localparam int NUM_STEP = 6;

   // phase index (0=U,1=V,2=W) sourcing in a step: two steps per phase
   function automatic logic [1:0] src_phase(input logic [2:0] s);
      return s[2:1];
   endfunction

   // sinking phase sits one or two places after the source, alternating
   function automatic logic [1:0] snk_phase(input logic [2:0] s);
      logic [2:0] t;
      t = {1'b0, s[2:1]} + 3'd1 + {2'b00, s[0]};
      if (t >= 3'd3) t = t - 3'd3;
      return t[1:0];
   endfunction
endpackage

// File: rtl/sss_mode_dec.sv
module sss_mode_dec #(
   parameter int BRAKE_CYC = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] en_sense,
   output logic       run,
   output logic       brake
);
   localparam int CW = $clog2(BRAKE_CYC + 1);

   generate
      if (BRAKE_CYC < 1) begin : g_bad_brake
         $error("BRAKE_CYC must be at least 1");
      end
   endgenerate

   logic          brake_req;
   logic [CW-1:0] hold;

   assign run       = (en_sense == 2'b11);
   assign brake_req = (en_sense == 2'b00);

   always_ff @(posedge clk) begin
      if (!rst_n)         hold <= '0;
      else if (brake_req) hold <= CW'(BRAKE_CYC);
      else if (run)       hold <= '0;
      else if (hold != '0) hold <= hold - 1'b1;
   end

   assign brake = brake_req | (!run & (hold != '0));
endmodule

// File: rtl/sss_force_timer.sv
module sss_force_timer #(
   parameter int START_LEN = 4,
   parameter int LEN_INC   = 2,
   parameter int MAX_LEN   = 16,
   parameter int FIRST_N   = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic tick,
   output logic adv
);
   localparam int LW = $clog2(MAX_LEN + 1);
   localparam int NW = $clog2(FIRST_N + 1);

   logic [LW-1:0] len;
   logic [LW-1:0] tcnt;
   logic [NW-1:0] nfirst;
   logic [LW:0]   grown;
   logic          last;

   assign last  = (tcnt == len - 1'b1);
   assign adv   = active & tick & last;
   assign grown = {1'b0, len} + (LW+1)'(LEN_INC);

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         len    <= LW'(START_LEN);
         tcnt   <= '0;
         nfirst <= '0;
      end else if (tick) begin
         if (last) begin
            tcnt <= '0;
            if (nfirst < NW'(FIRST_N - 1)) nfirst <= nfirst + 1'b1;
            else if (grown > (LW+1)'(MAX_LEN)) len <= LW'(MAX_LEN);
            else len <= grown[LW-1:0];
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sss_stall_watch.sv
module sss_stall_watch #(
   parameter int STALL_TICKS = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic tick,
   input  logic zc,
   output logic stall
);
   localparam int CW = $clog2(STALL_TICKS + 1);

   logic [CW-1:0] cnt;

   assign stall = active & tick & !zc & (cnt == CW'(STALL_TICKS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)                      cnt <= '0;
      else if (!active || zc || stall) cnt <= '0;
      else if (tick)                   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sss_phase_map.sv
module sss_phase_map
   import sss_pkg::*;
(
   input  logic       ph_en,
   input  logic       brake,
   input  logic [2:0] step,
   output logic [5:0] phase_cmd
);
   logic [1:0] src_p;
   logic [1:0] snk_p;

   assign src_p = src_phase(step);
   assign snk_p = snk_phase(step);

   generate
      for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
         assign phase_cmd[2*p +: 2] =
            brake            ? PH_SNK :
            !ph_en           ? PH_OFF :
            (src_p == 2'(p)) ? PH_SRC :
            (snk_p == 2'(p)) ? PH_SNK : PH_OFF;
      end
   endgenerate
endmodule

// File: rtl/spin_start_seq.sv
module spin_start_seq
   import sss_pkg::*;
#(
   parameter int START_LEN   = 4,
   parameter int LEN_INC     = 2,
   parameter int MAX_LEN     = 16,
   parameter int FIRST_N     = 5,
   parameter int LOCK_ZC     = 2,
   parameter int STALL_TICKS = 50000,
   parameter int BRAKE_CYC   = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] en_sense,
   input  logic       tick,
   input  logic       zc,
   input  logic       restart_inh,
   output logic [5:0] phase_cmd,
   output logic       sync_mode,
   output logic       halted
);
   generate
      if (START_LEN < 1 || START_LEN > MAX_LEN) begin : g_bad_len
         $error("START_LEN must lie in 1..MAX_LEN");
      end
      if (LEN_INC < 0 || FIRST_N < 1) begin : g_bad_ramp
         $error("LEN_INC must be >= 0 and FIRST_N >= 1");
      end
      if (LOCK_ZC < 1 || STALL_TICKS < 1) begin : g_bad_cnt
         $error("LOCK_ZC and STALL_TICKS must be >= 1");
      end
   endgenerate

   seq_st_e    st;
   logic [2:0] step;
   logic [2:0] step_nxt;
   logic       run;
   logic       brake;
   logic       adv;
   logic       stall;
   logic       lock;
   logic       forcing;
   logic       syncing;

   assign forcing  = (st == ST_FORCE);
   assign syncing  = (st == ST_SYNC);
   assign step_nxt = (step == 3'(NUM_STEP - 1)) ? 3'd0 : step + 3'd1;

   sss_mode_dec #(.BRAKE_CYC(BRAKE_CYC)) u_mode (
      .clk(clk), .rst_n(rst_n), .en_sense(en_sense), .run(run), .brake(brake)
   );

   sss_force_timer #(
      .START_LEN(START_LEN), .LEN_INC(LEN_INC),
      .MAX_LEN(MAX_LEN), .FIRST_N(FIRST_N)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .active(forcing), .tick(tick), .adv(adv)
   );

   sss_stall_watch #(.STALL_TICKS(STALL_TICKS)) u_stall (
      .clk(clk), .rst_n(rst_n), .active(syncing), .tick(tick), .zc(zc),
      .stall(stall)
   );

   generate
      if (LOCK_ZC == 1) begin : g_lock_direct
         assign lock = forcing & zc;
      end else begin : g_lock_count
         localparam int ZW = $clog2(LOCK_ZC);
         logic [ZW-1:0] zcnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !forcing) zcnt <= '0;
            else if (zc)            zcnt <= zcnt + 1'b1;
         end
         assign lock = forcing & zc & (zcnt == ZW'(LOCK_ZC - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         st   <= ST_IDLE;
         step <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               st   <= ST_FORCE;
               step <= '0;
            end
            ST_FORCE: begin
               if (lock)     st   <= ST_SYNC;
               else if (adv) step <= step_nxt;
            end
            ST_SYNC: begin
               if (stall) begin
                  st   <= restart_inh ? ST_HALT : ST_FORCE;
                  step <= '0;
               end else if (zc) begin
                  step <= step_nxt;
               end
            end
            default: st <= ST_HALT;
         endcase
      end
   end

   sss_phase_map u_map (
      .ph_en(run & (forcing | syncing)), .brake(brake), .step(step),
      .phase_cmd(phase_cmd)
   );

   assign sync_mode = syncing;
   assign halted    = (st == ST_HALT);
endmodule

// File: rtl/spin_start_chk.sv
module spin_start_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] en_sense,
   input logic       zc,
   input logic       restart_inh,
   input logic [5:0] phase_cmd,
   input logic       sync_mode,
   input logic       halted
);
   logic [2:0] is_src;
   logic [2:0] is_snk;

   assign is_src = {phase_cmd[5:4] == 2'b01, phase_cmd[3:2] == 2'b01, phase_cmd[1:0] == 2'b01};
   assign is_snk = {phase_cmd[5:4] == 2'b10, phase_cmd[3:2] == 2'b10, phase_cmd[1:0] == 2'b10};

   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      phase_cmd[1:0] != 2'b11 && phase_cmd[3:2] != 2'b11 && phase_cmd[5:4] != 2'b11); // R3

   AST_ONE_SRC_ONE_SNK: assert property (@(posedge clk) disable iff (!rst_n)
      (en_sense == 2'b11 && phase_cmd != 6'd0) |->
         ($countones(is_src) == 1 && $countones(is_snk) == 1)); // R3

   AST_BRAKE_ALL_SINK: assert property (@(posedge clk) disable iff (!rst_n)
      (en_sense == 2'b00) |-> (phase_cmd == 6'b101010)); // R1

   AST_OPEN_OFF_OR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en_sense == 2'b10 || en_sense == 2'b01) |->
         (phase_cmd == 6'd0 || phase_cmd == 6'b101010)); // R11

   AST_SYNC_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      sync_mode |-> $past(en_sense == 2'b11)); // R10

   AST_SYNC_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && $past(sync_mode) && !$past(zc) &&
       en_sense == 2'b11 && $past(en_sense == 2'b11)) |-> $stable(phase_cmd)); // R7

   AST_HALT_NEEDS_INH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> $past(restart_inh)); // R9

   AST_HALT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && en_sense == 2'b11) |-> (phase_cmd == 6'd0)); // R9
endmodule

bind spin_start_seq spin_start_chk u_chk (
   .clk(clk), .rst_n(rst_n), .en_sense(en_sense), .zc(zc),
   .restart_inh(restart_inh), .phase_cmd(phase_cmd),
   .sync_mode(sync_mode), .halted(halted)
);

// File: tb/tb_spin_start_seq.sv
module tb_spin_start_seq;
   localparam int CLK_P  = 10;
   localparam int STALL  = 8;
   localparam int BRKC   = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] en_sense = 2'b10;
   logic       tick = 1'b0;
   logic       zc = 1'b0;
   logic       restart_inh = 1'b0;
   logic [5:0] phase_cmd;
   logic       sync_mode;
   logic       halted;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   logic [7:0] q_val[$];
   string      q_tag[$];

   // R3 step table, W:V:U
   localparam logic [5:0] STEPW [6] = '{6'b001001, 6'b100001, 6'b100100,
                                        6'b000110, 6'b010010, 6'b011000};
   localparam logic [7:0] OFF  = 8'h00;
   localparam logic [7:0] BRK  = {2'b00, 6'b101010};
   localparam logic [7:0] HALT = {2'b10, 6'b000000};

   spin_start_seq #(.STALL_TICKS(STALL), .BRAKE_CYC(BRKC)) dut (
      .clk(clk), .rst_n(rst_n), .en_sense(en_sense), .tick(tick), .zc(zc),
      .restart_inh(restart_inh), .phase_cmd(phase_cmd),
      .sync_mode(sync_mode), .halted(halted)
   );

   always #(CLK_P/2) clk = ~clk;

   function automatic logic [7:0] fw(input int s);
      return {2'b00, STEPW[s % 6]};
   endfunction
   function automatic logic [7:0] sw(input int s);
      return {2'b01, STEPW[s % 6]};
   endfunction

   // driver: apply inputs for one cycle and queue the result expected after its edge
   task automatic cyc(input logic [1:0] en, input logic t, input logic z,
                      input logic inh, input logic [7:0] expv, input string tag);
      @(negedge clk);
      en_sense    = en;
      tick        = t;
      zc          = z;
      restart_inh = inh;
      q_val.push_back(expv);
      q_tag.push_back(tag);
   endtask

   // monitor: compare a quarter period after each rising edge
   always @(posedge clk) begin
      logic [7:0] ev;
      logic [7:0] act;
      string      tg;
      #(CLK_P/4);
      if (q_val.size() > 0) begin
         ev  = q_val.pop_front();
         tg  = q_tag.pop_front();
         act = {halted, sync_mode, phase_cmd};
         n_cmp++;
         if (act !== ev) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tg, act, ev);
         end
      end
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int s;
      int len;
      cyc(2'b11, 1'b1, 1'b1, 1'b0, OFF, "R2 reset holds off");
      cyc(2'b11, 1'b0, 1'b0, 1'b0, OFF, "R2 reset holds off");
      @(negedge clk);
      en_sense = 2'b10;
      rst_n = 1'b1;

      cyc(2'b10, 1'b0, 1'b0, 1'b0, OFF, "R1 open is off");
      cyc(2'b01, 1'b0, 1'b0, 1'b0, OFF, "R1 code 01 is open");
      cyc(2'b10, 1'b1, 1'b1, 1'b0, OFF, "R1 tick/zc ignored in open");

      // forced start with growing step length
      cyc(2'b11, 1'b0, 1'b0, 1'b0, fw(0), "R4 entry at step 0");
      s = 0;
      for (int n = 0; n < 12; n++) begin
         len = (n < 5) ? 4 : ((4 + 2*(n-4)) > 16 ? 16 : 4 + 2*(n-4));
         for (int t = 1; t <= len; t++) begin
            if (t == len) s = (s + 1) % 6;
            cyc(2'b11, 1'b1, 1'b0, 1'b0, fw(s), (n < 5) ? "R4 start step" : "R5 ramp step");
            cyc(2'b11, 1'b0, 1'b0, 1'b0, fw(s), "R4 idle cycle not counted");
         end
      end

      // handover
      cyc(2'b11, 1'b0, 1'b1, 1'b0, fw(s), "R6 first crossing no lock");
      cyc(2'b11, 1'b0, 1'b0, 1'b0, fw(s), "R6 still forced");
      cyc(2'b11, 1'b0, 1'b1, 1'b0, sw(s), "R6 lock on 2nd crossing");

      // back-EMF driven
      for (int k = 0; k < 3; k++) cyc(2'b11, 1'b1, 1'b0, 1'b0, sw(s), "R7 tick no advance");
      s++; cyc(2'b11, 1'b0, 1'b1, 1'b0, sw(s), "R7 crossing advances");
      s++; cyc(2'b11, 1'b0, 1'b1, 1'b0, sw(s), "R7 crossing advances");

      // stall and restart
      for (int k = 1; k < STALL; k++) cyc(2'b11, 1'b1, 1'b0, 1'b0, sw(s), "R8 before timeout");
      cyc(2'b11, 1'b1, 1'b0, 1'b0, fw(0), "R8 restart at step 0");
      for (int k = 1; k < 4; k++) cyc(2'b11, 1'b1, 1'b0, 1'b0, fw(0), "R8 restarted 4T step");
      cyc(2'b11, 1'b1, 1'b0, 1'b0, fw(1), "R8 restarted 4T step ends");

      // stall with inhibit
      cyc(2'b11, 1'b0, 1'b1, 1'b1, fw(1), "R6 relock first");
      cyc(2'b11, 1'b0, 1'b1, 1'b1, sw(1), "R6 relock second");
      for (int k = 1; k < STALL; k++) cyc(2'b11, 1'b1, 1'b0, 1'b1, sw(1), "R9 before timeout");
      cyc(2'b11, 1'b1, 1'b0, 1'b1, HALT, "R9 halt on inhibited stall");
      for (int k = 0; k < 3; k++) cyc(2'b11, 1'b1, 1'b1, 1'b1, HALT, "R9 halt ignores tick/zc");
      cyc(2'b11, 1'b1, 1'b0, 1'b0, HALT, "R9 halt ignores inh drop");

      // leave and re-enter drive
      cyc(2'b10, 1'b0, 1'b0, 1'b0, OFF, "R10 open returns idle");
      cyc(2'b11, 1'b0, 1'b0, 1'b0, fw(0), "R10 rerun from step 0");
      for (int k = 1; k < 4; k++) cyc(2'b11, 1'b1, 1'b0, 1'b0, fw(0), "R10 rerun 4T step");
      cyc(2'b11, 1'b1, 1'b0, 1'b0, fw(1), "R10 rerun 4T step ends");

      // brake and its hold
      cyc(2'b00, 1'b0, 1'b0, 1'b0, BRK, "R1 brake all sink");
      cyc(2'b00, 1'b1, 1'b1, 1'b0, BRK, "R1 brake ignores tick/zc");
      for (int k = 1; k < BRKC; k++) cyc(2'b10, 1'b0, 1'b0, 1'b0, BRK, "R11 brake hold");
      cyc(2'b10, 1'b0, 1'b0, 1'b0, OFF, "R11 hold ends");
      cyc(2'b00, 1'b0, 1'b0, 1'b0, BRK, "R1 brake again");
      cyc(2'b11, 1'b0, 1'b0, 1'b0, fw(0), "R10 brake to drive");
      cyc(2'b10, 1'b0, 1'b0, 1'b0, OFF, "R11 no residual hold");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule